// File: doc/BRIEF.md
# Relational condition unit for compare, branch and trap operations

This unit evaluates one relation between two 32-bit values and turns the outcome into one of three results, depending on the operation family. For compare operations it produces a result word of exactly 0 or 1 and asks for a register write. For conditional branches it raises a taken flag. For conditional traps it raises a one-cycle trap request and writes nothing. A single comparator serves all three families.

The second comparand is either the second register operand or a 16-bit immediate. The unsigned bit of the operation code decides how the immediate is extended: it is sign-extended for signed operations and zero-extended for unsigned ones. The same bit selects unsigned ordering. Branches always compare the first register against zero. Each input strobe produces exactly one registered result one clock later.

Operation code `op[5:0]`: `op[5:4]` is the family (00 compare, 01 branch, 10 trap, 11 reserved). `op[3]` is the unsigned bit. `op[2:0]` is the relation (0 eq, 1 ne, 2 lt, 3 le, 4 gt, 5 ge; 6 and 7 reserved).

Top module: `cbt_unit`

## Requirements
- R1: While `rst_n` is low, and on the first edge after it rises with no strobe, `out_valid`, `res`, `res_we`, `br_taken` and `trap` are all 0.
- R2: A compare (family 00) with a valid relation produces, one clock after `in_valid`, `out_valid`=1 and `res_we`=1. `res` is 32'd1 if the relation holds and 32'd0 otherwise.
- R3: With `op[3]`=0, the relations lt, le, gt and ge order the operands as two's-complement signed numbers.
- R4: With `op[3]`=1, the relations lt, le, gt and ge order the operands as unsigned numbers.
- R5: With `use_imm`=1 and `op[3]`=0, the second comparand is `imm` sign-extended to 32 bits, and `b` is ignored.
- R6: With `use_imm`=1 and `op[3]`=1, the second comparand is `imm` zero-extended to 32 bits. This also applies to eq and ne.
- R7: A branch (family 01, `op[3]`=0) compares `a` against zero and ignores `b`, `imm` and `use_imm`. Branch-if-true uses the ne code (1) and branch-if-false uses the eq code (0).
- R8: A trap (family 10) raises `trap` for exactly the one output cycle of that operation when the relation holds. It keeps `res_we`=0 and `res`=0.
- R9: A branch gives `res_we`=0, `res`=0 and `trap`=0. `br_taken` is 1 only when the relation holds.
- R10: An unrecognised code gives `out_valid`=1 with `res`=0, `res_we`=0, `br_taken`=0 and `trap`=0. Unrecognised codes are family 11, relation 6 or 7, or a branch with `op[3]`=1.
- R11: A cycle with `in_valid`=0 gives, one clock later, `out_valid`=0 and all other outputs 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operation strobe |
| op | input | 6 | Family, unsigned bit, relation |
| use_imm | input | 1 | Select immediate as second comparand |
| a | input | 32 | First register operand |
| b | input | 32 | Second register operand |
| imm | input | 16 | Immediate field |
| out_valid | output | 1 | Result present |
| res | output | 32 | Compare result word (0 or 1) |
| res_we | output | 1 | Register write request |
| br_taken | output | 1 | Branch taken |
| trap | output | 1 | Trap request pulse |

## Verification
Every output is due exactly one rising edge after the strobe that caused it, with no further stage. The driver applies an operation on a falling edge and queues its expected outcome. The monitor samples one time unit after each rising edge: it pops one item whenever `out_valid` is high and otherwise checks that every output is idle. Because of this fixed spacing, back-to-back strobes, gaps and trap pulses each line up with exactly one queue entry.

// File: rtl/cbt_pkg.sv
package cbt_pkg;
    localparam int DATA_W = 32;
    localparam int IMM_W  = 16;
    localparam int OP_W   = 6;

    typedef enum logic [1:0] {
        FAM_CMP = 2'b00,
        FAM_BR  = 2'b01,
        FAM_TRP = 2'b10,
        FAM_RSV = 2'b11
    } fam_e;

    typedef enum logic [2:0] {
        REL_EQ = 3'd0,
        REL_NE = 3'd1,
        REL_LT = 3'd2,
        REL_LE = 3'd3,
        REL_GT = 3'd4,
        REL_GE = 3'd5
    } rel_e;

    typedef struct packed {
        logic              valid;
        logic [DATA_W-1:0] res;
        logic              we;
        logic              br;
        logic              trap;
    } out_t;
endpackage

// File: rtl/cbt_operand.sv
module cbt_operand #(
    parameter int DATA_W = 32,
    parameter int IMM_W  = 16
) (
    input  logic [DATA_W-1:0] b,
    input  logic [IMM_W-1:0]  imm,
    input  logic              use_imm,
    input  logic              uns,
    input  logic              force_zero,
    output logic [DATA_W-1:0] cmp_b
);
    localparam int PAD_W = DATA_W - IMM_W;

    logic [DATA_W-1:0] imm_ext;

    generate
        if (PAD_W > 0) begin : g_pad
            always_comb begin
                imm_ext = {{PAD_W{(~uns) & imm[IMM_W-1]}}, imm};
            end
        end else begin : g_trunc
            always_comb begin
                imm_ext = imm[DATA_W-1:0];
            end
        end
    endgenerate

    always_comb begin
        if (force_zero) begin
            cmp_b = '0;
        end else if (use_imm) begin
            cmp_b = imm_ext;
        end else begin
            cmp_b = b;
        end
    end
endmodule

// File: rtl/cbt_relation.sv
module cbt_relation
    import cbt_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0] x,
    input  logic [DATA_W-1:0] y,
    input  logic              uns,
    input  logic [2:0]        rel,
    output logic              hit,
    output logic              rel_ok
);
    logic eq;
    logic lt_u;
    logic lt_s;
    logic lt;

    always_comb begin
        eq   = (x == y);
        lt_u = (x < y);
        lt_s = ($signed(x) < $signed(y));
        lt   = uns ? lt_u : lt_s;
        hit    = 1'b0;
        rel_ok = 1'b1;
        case (rel)
            REL_EQ:  hit = eq;
            REL_NE:  hit = ~eq;
            REL_LT:  hit = lt;
            REL_LE:  hit = lt | eq;
            REL_GT:  hit = ~(lt | eq);
            REL_GE:  hit = ~lt;
            default: rel_ok = 1'b0;
        endcase
    end
endmodule

// File: rtl/cbt_unit.sv
module cbt_unit
    import cbt_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_valid,
    input  logic [OP_W-1:0]     op,
    input  logic                use_imm,
    input  logic [DATA_W-1:0]   a,
    input  logic [DATA_W-1:0]   b,
    input  logic [IMM_W-1:0]    imm,
    output logic                out_valid,
    output logic [DATA_W-1:0]   res,
    output logic                res_we,
    output logic                br_taken,
    output logic                trap
);
    fam_e              fam;
    logic              uns;
    logic [2:0]        rel;
    logic              is_br;
    logic [DATA_W-1:0] cmp_b;
    logic              hit;
    logic              rel_ok;
    out_t              st_d;
    out_t              st_q;

    always_comb begin
        fam   = fam_e'(op[5:4]);
        uns   = op[3];
        rel   = op[2:0];
        is_br = (fam == FAM_BR);
    end

    cbt_operand #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_operand (
        .b          (b),
        .imm        (imm),
        .use_imm    (use_imm),
        .uns        (uns),
        .force_zero (is_br),
        .cmp_b      (cmp_b)
    );

    cbt_relation #(.DATA_W(DATA_W)) u_relation (
        .x      (a),
        .y      (cmp_b),
        .uns    (uns),
        .rel    (rel),
        .hit    (hit),
        .rel_ok (rel_ok)
    );

    always_comb begin
        st_d = '0;
        if (in_valid) begin
            st_d.valid = 1'b1;
            if (rel_ok) begin
                case (fam)
                    FAM_CMP: begin
                        st_d.we  = 1'b1;
                        st_d.res = {{(DATA_W-1){1'b0}}, hit};
                    end
                    FAM_BR: begin
                        st_d.br = hit & ~uns;
                    end
                    FAM_TRP: begin
                        st_d.trap = hit;
                    end
                    default: ;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        out_valid = st_q.valid;
        res       = st_q.res;
        res_we    = st_q.we;
        br_taken  = st_q.br;
        trap      = st_q.trap;
    end
endmodule

// File: rtl/cbt_unit_chk.sv
module cbt_unit_chk
    import cbt_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic [OP_W-1:0]   op,
    input logic              use_imm,
    input logic [DATA_W-1:0] a,
    input logic [DATA_W-1:0] b,
    input logic [IMM_W-1:0]  imm,
    input logic              out_valid,
    input logic [DATA_W-1:0] res,
    input logic              res_we,
    input logic              br_taken,
    input logic              trap
);
    p_lat_r2: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    p_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && res == '0 && !res_we && !br_taken && !trap));
    p_bool_r2: assert property (@(posedge clk) disable iff (!rst_n)
        res_we |-> (res[DATA_W-1:1] == '0));
    p_trap_nowrite_r8: assert property (@(posedge clk) disable iff (!rst_n)
        trap |-> (!res_we && res == '0 && !br_taken));
    p_br_nowrite_r9: assert property (@(posedge clk) disable iff (!rst_n)
        br_taken |-> (!res_we && res == '0 && !trap));
    p_rsv_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op[5:4] == 2'b11) |=> (!res_we && !br_taken && !trap && res == '0));
    p_cmp_we_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op[5:4] == 2'b00 && op[2:0] < 3'd6) |=> res_we);
endmodule

bind cbt_unit cbt_unit_chk u_chk (.*);

// File: tb/cbt_unit_bench.sv
module cbt_unit_bench;
    typedef struct {
        logic [31:0] res;
        logic        we;
        logic        br;
        logic        trp;
        string       tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [5:0]  op = '0;
    logic        use_imm = 1'b0;
    logic [31:0] a = '0;
    logic [31:0] b = '0;
    logic [15:0] imm = '0;
    logic        out_valid;
    logic [31:0] res;
    logic        res_we;
    logic        br_taken;
    logic        trap;

    int   n_checks = 0;
    int   n_fail = 0;
    bit   done = 1'b0;
    bit   mon_on = 1'b0;
    exp_t q[$];

    always #2.5 clk = ~clk;

    cbt_unit u_cbt_unit (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op),
        .use_imm(use_imm), .a(a), .b(b), .imm(imm),
        .out_valid(out_valid), .res(res), .res_we(res_we),
        .br_taken(br_taken), .trap(trap)
    );

    function automatic bit rel_true(input logic [2:0] r, input bit u,
                                    input logic [31:0] x, input logic [31:0] y);
        bit less;
        less = u ? (x < y) : ($signed(x) < $signed(y));
        case (r)
            3'd0: return x == y;
            3'd1: return x != y;
            3'd2: return less;
            3'd3: return less || x == y;
            3'd4: return !less && x != y;
            3'd5: return !less;
            default: return 1'b0;
        endcase
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic issue(input logic [5:0] o, input bit ui, input logic [31:0] xa,
                         input logic [31:0] xb, input logic [15:0] xi, input string tag);
        exp_t e;
        logic [31:0] y;
        bit h;
        bit u;
        u = o[3];
        y = ui ? (u ? {16'h0, xi} : {{16{xi[15]}}, xi}) : xb;
        if (o[5:4] == 2'b01) y = 32'h0;
        h = rel_true(o[2:0], u, xa, y);
        e.res = '0; e.we = 0; e.br = 0; e.trp = 0; e.tag = tag;
        if (o[2:0] < 3'd6) begin
            case (o[5:4])
                2'b00: begin e.we = 1; e.res = {31'h0, h}; end
                2'b01: e.br = h && !u;
                2'b10: e.trp = h;
                default: ;
            endcase
        end
        @(negedge clk);
        in_valid = 1; op = o; use_imm = ui; a = xa; b = xb; imm = xi;
        q.push_back(e);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 0;
        end
    endtask

    initial begin : monitor
        forever begin
            @(posedge clk);
            #1;
            if (mon_on) begin
                if (out_valid) begin
                    if (q.size() == 0) begin
                        check(0, "R11", "unexpected out_valid", 32'h1, 32'h0);
                    end else begin
                        exp_t e;
                        e = q.pop_front();
                        check(res == e.res, e.tag, "res", res, e.res);
                        check(res_we == e.we, e.tag, "res_we", {31'h0, res_we}, {31'h0, e.we});
                        check(br_taken == e.br, e.tag, "br_taken", {31'h0, br_taken}, {31'h0, e.br});
                        check(trap == e.trp, e.tag, "trap", {31'h0, trap}, {31'h0, e.trp});
                    end
                end else begin
                    check(res == 0 && !res_we && !br_taken && !trap, "R11", "idle outputs",
                          {28'h0, res_we, br_taken, trap, |res}, 32'h0);
                end
            end
        end
    end

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            check(0, "R1", "watchdog expired", 32'h0, 32'h1);
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin : driver
        repeat (3) @(posedge clk);
        #1;
        check(!out_valid && res == 0 && !res_we && !br_taken && !trap, "R1", "reset outputs",
              {28'h0, out_valid, res_we, br_taken, trap}, 32'h0);
        @(negedge clk);
        rst_n = 1;
        @(posedge clk);
        #1;
        check(!out_valid && !trap, "R1", "first edge after reset",
              {30'h0, out_valid, trap}, 32'h0);
        mon_on = 1;
        // R2 compare register forms
        issue(6'b00_0_000, 0, 32'd5, 32'd5, 16'h0, "R2");
        issue(6'b00_0_001, 0, 32'd5, 32'd5, 16'h0, "R2");
        // R3 signed ordering
        issue(6'b00_0_010, 0, 32'hFFFF_FFFF, 32'd1, 16'h0, "R3");
        issue(6'b00_0_100, 0, 32'hFFFF_FFFF, 32'd1, 16'h0, "R3");
        issue(6'b00_0_011, 0, 32'h8000_0000, 32'h8000_0000, 16'h0, "R3");
        issue(6'b00_0_101, 0, 32'h7FFF_FFFF, 32'h8000_0000, 16'h0, "R3");
        // R4 unsigned ordering
        issue(6'b00_1_010, 0, 32'hFFFF_FFFF, 32'd1, 16'h0, "R4");
        issue(6'b00_1_100, 0, 32'hFFFF_FFFF, 32'd1, 16'h0, "R4");
        issue(6'b00_1_011, 0, 32'd7, 32'd7, 16'h0, "R4");
        idle(2);
        // R5 signed immediate, b ignored
        issue(6'b00_0_000, 1, 32'hFFFF_FFF0, 32'hFFFF_FFF0, 16'hFFF0, "R5");
        issue(6'b00_0_010, 1, 32'd5, 32'd100, 16'h8000, "R5");
        // R6 unsigned immediate, including eq and ne
        issue(6'b00_1_000, 1, 32'hFFFF_FFF0, 32'h0, 16'hFFF0, "R6");
        issue(6'b00_1_001, 1, 32'hFFFF_FFF0, 32'h0, 16'hFFF0, "R6");
        issue(6'b00_1_000, 1, 32'h0000_FFF0, 32'h1, 16'hFFF0, "R6");
        issue(6'b00_1_010, 1, 32'd5, 32'd0, 16'h8000, "R6");
        // R7 / R9 branches against zero
        issue(6'b01_0_000, 0, 32'd0, 32'd7, 16'h1234, "R7");
        issue(6'b01_0_001, 1, 32'd0, 32'd7, 16'h1234, "R7");
        issue(6'b01_0_001, 0, 32'd9, 32'd9, 16'h0, "R7");
        issue(6'b01_0_010, 0, 32'hFFFF_FFFD, 32'd0, 16'h0, "R9");
        issue(6'b01_0_101, 0, 32'd0, 32'hFFFF_FFFF, 16'h0, "R9");
        issue(6'b01_0_100, 0, 32'd0, 32'hFFFF_FFFF, 16'h0, "R9");
        issue(6'b01_0_011, 0, 32'd3, 32'd0, 16'h0, "R9");
        idle(1);
        // R8 traps, back to back then isolated
        issue(6'b10_0_000, 0, 32'd42, 32'd42, 16'h0, "R8");
        issue(6'b10_0_000, 0, 32'd42, 32'd43, 16'h0, "R8");
        issue(6'b10_0_010, 1, 32'hFFFF_FFFF, 32'd0, 16'h0001, "R8");
        issue(6'b10_1_010, 1, 32'hFFFF_FFFF, 32'd0, 16'h0001, "R8");
        idle(1);
        issue(6'b10_1_101, 0, 32'd3, 32'd2, 16'h0, "R8");
        idle(2);
        // R10 unrecognised codes
        issue(6'b11_0_000, 0, 32'd1, 32'd1, 16'h0, "R10");
        issue(6'b00_0_110, 0, 32'd1, 32'd1, 16'h0, "R10");
        issue(6'b10_0_111, 0, 32'd1, 32'd1, 16'h0, "R10");
        issue(6'b01_1_000, 0, 32'd0, 32'd0, 16'h0, "R10");
        idle(2);
        // mixed pseudo-random sweep
        for (int i = 0; i < 200; i++) begin
            logic [5:0] ro;
            logic [31:0] ra;
            logic [31:0] rb;
            ro = 6'($urandom);
            ra = $urandom;
            rb = ($urandom % 4 == 0) ? ra : $urandom;
            issue(ro, 1'($urandom), ra, rb, 16'($urandom), "R2");
            if (i % 7 == 0) idle(1);
        end
        idle(3);
        check(q.size() == 0, "R11", "queue drained", q.size(), 32'h0);
        done = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule